// File: doc/BRIEF.md
# Multi-Group Conversion Sequencer for a Successive-Approximation Converter

This block is the digital controller that sits in front of a single successive-approximation converter core and shares it between several channel groups. Each group has its own small control word: a 5-bit channel number, an interrupt enable, a conversion-complete flag and a result register. Exactly one group owns the converter at any moment. The block divides the module clock down to the converter clock, applies the selected sample length, counts the fixed conversion clocks, and then hands off the result and a one-cycle done strobe.

Triggering works in one of two ways. In software mode, writing the control word of group 0 starts a conversion, and writes to any other group only update that group's stored settings. In hardware mode, conversions start on pulses of the trigger input, and successive triggers move round the groups in turn. A write to the group that is converting cancels its conversion. A write to any other group leaves the running conversion alone. With continuous mode set, each completed conversion starts the next one at once. The analog core is stood in for by a sample-data input, which is captured on the clock edge that ends the conversion.

Top module: `adc_group_seq`

## Requirements
- R1: After reset, `active`, `done_pulse`, `irq` and every bit of `flags` are 0.
- R2: In software mode (`hw_en`=0), a write to group 0 that is sampled at clock edge E starts a conversion. `active` is 1 from edge E until edge E+N, where N is the conversion length in module clocks. At edge E+N, `active` falls, `done_pulse` is high for one cycle, `done_grp` holds the group, and `done_data` holds the `smp_data` value that was sampled at that edge. `conv_ch` shows the channel of the converting group.
- R3: The `div_code` values 0, 1, 2 and 3 set a converter clock period of 1, 2, 4 and 8 module clocks.
- R4: N = D × (S + DW + 2), where D is the divider from R3 and S is the number of sample clocks. The `ls_code` values 0, 1, 2 and 3 give S = 24, 16, 10 and 6. Any `ls_code` of 4 or more gives S = 4.
- R5: In software mode, a write to a group other than 0 never starts a conversion.
- R6: In hardware mode, a `hw_trig` pulse sampled while the block is idle starts a conversion on the group named by a turn pointer. The pointer starts at 0 and advances by one (wrapping at NGRP) on each such start. A trigger that arrives while a conversion is running is ignored and does not move the pointer. Writes do not start conversions in hardware mode.
- R7: In hardware mode, a write to the group that is converting aborts the conversion. `active` falls at the write edge, no done strobe follows, and the group's flag is not set.
- R8: A write to a group other than the converting one leaves that conversion running, and it ends at its normal edge.
- R9: At completion, the flag of the finished group is set. `irq` is the OR, over all groups, of flag AND interrupt enable.
- R10: `rd_data` shows the result register of the group `rd_grp` selects. A clock edge with `rd_en` high clears that group's flag. A write to a group also clears its flag.
- R11: If `cont_en` is 1 at the edge where a conversion ends, a new conversion on the same group starts at that edge. `active` stays high, and the next done strobe comes N cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for a group control word |
| wr_grp | input | GW | Group being written |
| wr_ch | input | CHW | Channel number to store (0 to 31) |
| wr_ie | input | 1 | Interrupt enable to store |
| rd_en | input | 1 | Result read strobe; clears the flag of the group read |
| rd_grp | input | GW | Group whose result is shown on rd_data |
| rd_data | output | DW | Result register of the group rd_grp selects |
| hw_en | input | 1 | 1 selects hardware-trigger mode |
| hw_trig | input | 1 | Hardware trigger pulse |
| cont_en | input | 1 | Continuous conversion mode |
| div_code | input | 2 | Converter clock divider code |
| ls_code | input | 3 | Sample length code |
| smp_data | input | DW | Stand-in for the analog core output |
| active | output | 1 | High while a conversion is running |
| conv_ch | output | CHW | Channel number of the converting group |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_grp | output | GW | Group that just completed |
| done_data | output | DW | Result of the group that just completed |
| flags | output | NGRP | Conversion-complete flag of each group |
| irq | output | 1 | Interrupt request |

## Verification
The timing is tried with four pairs of divider and sample codes. Each pair gives a different total length (24, 76, 120 and 160 cycles), so a wrong divider, a wrong sample table or a missing conversion-clock term moves the done strobe to a different cycle. Software starts on group 0 are set against writes to group 1 that must stay silent. In hardware mode, a sequence of an abort, a write to an idle group, an ignored mid-conversion trigger and a wrap of the turn pointer separates correct ping-pong order from a pointer that advances on ignored triggers or a write that disturbs the wrong group. A continuous run of three back-to-back conversions shows that a restart starts a new count, and that turning the mode off lets the current conversion end cleanly. Every done strobe is checked against a queued expectation of its cycle, group and captured data.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef logic [1:0] div_code_t;
  typedef logic [2:0] ls_code_t;

  // sample length when no extension is selected
  localparam int unsigned BASE_SAMPLE_CLKS = 4;
  // conversion clocks beyond the result width
  localparam int unsigned CONV_EXTRA_CLKS  = 2;
  // longest sample length, used to size counters
  localparam int unsigned MAX_SAMPLE_CLKS  = 24;

  function automatic int unsigned sample_clocks(input ls_code_t code);
    case (code)
      3'd0:    return 24;
      3'd1:    return 16;
      3'd2:    return 10;
      3'd3:    return 6;
      default: return BASE_SAMPLE_CLKS;
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
`timescale 1ns/1ps
module adc_seq_clkdiv
  import adc_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      restart,
  input  div_code_t div_code,
  output logic      tick
);
  logic [2:0] cnt_q, cnt_d, limit;

  always_comb begin
    case (div_code)
      2'd0:    limit = 3'd0;
      2'd1:    limit = 3'd1;
      2'd2:    limit = 3'd3;
      default: limit = 3'd7;
    endcase
  end

  assign tick = en && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (en)  cnt_d = cnt_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NGRP = 2,
  parameter int GW   = 1,
  parameter int DW   = 12,
  parameter int CW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [GW-1:0] wr_grp,
  input  logic          hw_en,
  input  logic          hw_trig,
  input  logic          cont_en,
  input  div_code_t     div_code,
  input  ls_code_t      ls_code,
  input  logic          tick,
  output logic          active,
  output logic [GW-1:0] cur_grp,
  output logic          start,
  output logic          fin_done,
  output logic          done_pulse,
  output logic [GW-1:0] done_grp,
  output div_code_t     div_q
);
  logic          act_q, act_d;
  logic [GW-1:0] grp_q, grp_d, ptr_q, ptr_d, dgrp_q, dgrp_d;
  logic [CW-1:0] ccnt_q, ccnt_d, tot_q, tot_d;
  div_code_t     div_d;
  logic          dp_q;
  logic          sw_start, hw_start, abort_w, fin, cont_start;
  logic [GW-1:0] start_grp;

  assign sw_start   = !hw_en && wr_en && (wr_grp == '0);
  assign hw_start   = hw_en && hw_trig && !act_q;
  assign abort_w    = act_q && wr_en && (wr_grp == grp_q) && !sw_start;
  assign fin        = act_q && tick && (ccnt_q == tot_q - CW'(1));
  assign fin_done   = fin && !abort_w && !sw_start;
  assign cont_start = fin_done && cont_en;
  assign start      = sw_start || hw_start || cont_start;

  always_comb begin
    if (sw_start)      start_grp = '0;
    else if (hw_start) start_grp = ptr_q;
    else               start_grp = grp_q;
  end

  always_comb begin
    act_d  = act_q;
    grp_d  = grp_q;
    ptr_d  = ptr_q;
    ccnt_d = ccnt_q;
    tot_d  = tot_q;
    div_d  = div_q;
    dgrp_d = dgrp_q;
    if (start) begin
      act_d  = 1'b1;
      grp_d  = start_grp;
      ccnt_d = '0;
      tot_d  = CW'(sample_clocks(ls_code) + DW + CONV_EXTRA_CLKS);
      div_d  = div_code;
    end else begin
      if (abort_w || fin_done) act_d = 1'b0;
      if (tick)                ccnt_d = ccnt_q + CW'(1);
    end
    if (hw_start)
      ptr_d = (ptr_q == GW'(NGRP-1)) ? '0 : ptr_q + GW'(1);
    if (fin_done)
      dgrp_d = grp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      grp_q  <= '0;
      ptr_q  <= '0;
      ccnt_q <= '0;
      tot_q  <= '0;
      div_q  <= '0;
      dgrp_q <= '0;
      dp_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      grp_q  <= grp_d;
      ptr_q  <= ptr_d;
      ccnt_q <= ccnt_d;
      tot_q  <= tot_d;
      div_q  <= div_d;
      dgrp_q <= dgrp_d;
      dp_q   <= fin_done;
    end
  end

  assign active     = act_q;
  assign cur_grp    = grp_q;
  assign done_pulse = dp_q;
  assign done_grp   = dgrp_q;
endmodule

// File: rtl/adc_seq_regbank.sv
`timescale 1ns/1ps
module adc_seq_regbank #(
  parameter int NGRP = 2,
  parameter int GW   = 1,
  parameter int CHW  = 5,
  parameter int DW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [GW-1:0]   wr_grp,
  input  logic [CHW-1:0]  wr_ch,
  input  logic            wr_ie,
  input  logic            rd_en,
  input  logic [GW-1:0]   rd_grp,
  input  logic            set_en,
  input  logic [GW-1:0]   set_grp,
  input  logic [DW-1:0]   smp_data,
  input  logic [GW-1:0]   sel_grp,
  input  logic [GW-1:0]   dsel_grp,
  output logic [CHW-1:0]  sel_ch,
  output logic [DW-1:0]   rd_data,
  output logic [DW-1:0]   done_data,
  output logic [NGRP-1:0] flags,
  output logic [NGRP-1:0] ie_vec,
  output logic            irq
);
  logic [NGRP-1:0][CHW-1:0] ch_all;
  logic [NGRP-1:0][DW-1:0]  res_all;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [CHW-1:0] ch_q, ch_d;
    logic           ie_q, ie_d, fl_q, fl_d;
    logic [DW-1:0]  res_q, res_d;
    logic           hit_wr, hit_rd, hit_set;

    assign hit_wr  = wr_en  && (wr_grp  == GW'(g));
    assign hit_rd  = rd_en  && (rd_grp  == GW'(g));
    assign hit_set = set_en && (set_grp == GW'(g));

    always_comb begin
      ch_d  = ch_q;
      ie_d  = ie_q;
      fl_d  = fl_q;
      res_d = res_q;
      if (hit_wr) begin
        ch_d = wr_ch;
        ie_d = wr_ie;
        fl_d = 1'b0;
      end
      if (hit_rd) fl_d = 1'b0;
      if (hit_set) begin
        fl_d  = 1'b1;
        res_d = smp_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_q  <= '0;
        ie_q  <= 1'b0;
        fl_q  <= 1'b0;
        res_q <= '0;
      end else begin
        ch_q  <= ch_d;
        ie_q  <= ie_d;
        fl_q  <= fl_d;
        res_q <= res_d;
      end
    end

    assign ch_all[g]  = ch_q;
    assign res_all[g] = res_q;
    assign flags[g]   = fl_q;
    assign ie_vec[g]  = ie_q;
  end

  assign sel_ch    = ch_all[sel_grp];
  assign rd_data   = res_all[rd_grp];
  assign done_data = res_all[dsel_grp];
  assign irq       = |(flags & ie_vec);
endmodule

// File: rtl/adc_group_seq.sv
`timescale 1ns/1ps
module adc_group_seq
  import adc_seq_pkg::*;
#(
  parameter int NGRP = 2,
  parameter int GW   = (NGRP > 1) ? $clog2(NGRP) : 1,
  parameter int CHW  = 5,
  parameter int DW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [GW-1:0]   wr_grp,
  input  logic [CHW-1:0]  wr_ch,
  input  logic            wr_ie,
  input  logic            rd_en,
  input  logic [GW-1:0]   rd_grp,
  output logic [DW-1:0]   rd_data,
  input  logic            hw_en,
  input  logic            hw_trig,
  input  logic            cont_en,
  input  logic [1:0]      div_code,
  input  logic [2:0]      ls_code,
  input  logic [DW-1:0]   smp_data,
  output logic            active,
  output logic [CHW-1:0]  conv_ch,
  output logic            done_pulse,
  output logic [GW-1:0]   done_grp,
  output logic [DW-1:0]   done_data,
  output logic [NGRP-1:0] flags,
  output logic            irq
);
  localparam int CW = $clog2(MAX_SAMPLE_CLKS + DW + CONV_EXTRA_CLKS + 1);

  logic [1:0]      rsync_q;
  logic            rst_q_n;
  logic            tick, start, fin_done;
  logic [GW-1:0]   cur_grp;
  div_code_t       div_q;
  logic [NGRP-1:0] ie_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  adc_seq_clkdiv u_div (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .en       (active),
    .restart  (start),
    .div_code (div_q),
    .tick     (tick)
  );

  adc_seq_ctrl #(.NGRP(NGRP), .GW(GW), .DW(DW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .wr_en      (wr_en),
    .wr_grp     (wr_grp),
    .hw_en      (hw_en),
    .hw_trig    (hw_trig),
    .cont_en    (cont_en),
    .div_code   (div_code),
    .ls_code    (ls_code),
    .tick       (tick),
    .active     (active),
    .cur_grp    (cur_grp),
    .start      (start),
    .fin_done   (fin_done),
    .done_pulse (done_pulse),
    .done_grp   (done_grp),
    .div_q      (div_q)
  );

  adc_seq_regbank #(.NGRP(NGRP), .GW(GW), .CHW(CHW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en     (wr_en),
    .wr_grp    (wr_grp),
    .wr_ch     (wr_ch),
    .wr_ie     (wr_ie),
    .rd_en     (rd_en),
    .rd_grp    (rd_grp),
    .set_en    (fin_done),
    .set_grp   (cur_grp),
    .smp_data  (smp_data),
    .sel_grp   (cur_grp),
    .dsel_grp  (done_grp),
    .sel_ch    (conv_ch),
    .rd_data   (rd_data),
    .done_data (done_data),
    .flags     (flags),
    .ie_vec    (ie_vec),
    .irq       (irq)
  );
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int NGRP = 2,
  parameter int GW   = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [GW-1:0]   wr_grp,
  input logic            rd_en,
  input logic [GW-1:0]   rd_grp,
  input logic            hw_en,
  input logic            hw_trig,
  input logic            cont_en,
  input logic            active,
  input logic [GW-1:0]   cur_grp,
  input logic            fin_done,
  input logic            done_pulse,
  input logic [GW-1:0]   done_grp,
  input logic [NGRP-1:0] flags
);
  // R2: the done strobe lasts a single cycle and follows a running conversion
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  a_r2_done_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(active));

  // R5: idle in software mode without a group-0 write stays idle
  a_r5_no_side_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_en && !active && !(wr_en && wr_grp == '0)) |=> !active);

  // R6: idle in hardware mode without a trigger stays idle
  a_r6_trigger_only: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && !active && !hw_trig) |=> !active);

  // R7: a write to the converting group in hardware mode cancels it
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && active && wr_en && wr_grp == cur_grp) |=> (!active && !done_pulse));

  // R9: the finished group's flag is up with the strobe
  a_r9_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> flags[done_grp]);

  // R10: a read clears the flag unless a completion lands on the same edge
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fin_done) |=> !flags[$past(rd_grp)]);

  // R11: continuous mode keeps the converter busy across a completion
  a_r11_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && $past(cont_en)) |-> active);
endmodule

bind adc_group_seq adc_seq_chk #(.NGRP(NGRP), .GW(GW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .wr_en      (wr_en),
  .wr_grp     (wr_grp),
  .rd_en      (rd_en),
  .rd_grp     (rd_grp),
  .hw_en      (hw_en),
  .hw_trig    (hw_trig),
  .cont_en    (cont_en),
  .active     (active),
  .cur_grp    (cur_grp),
  .fin_done   (fin_done),
  .done_pulse (done_pulse),
  .done_grp   (done_grp),
  .flags      (flags)
);

// File: tb/sim_adc_group_seq.sv
`timescale 1ns/1ps
module sim_adc_group_seq;
  localparam int NGRP = 2;
  localparam int GW   = 1;
  localparam int CHW  = 5;
  localparam int DW   = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en, wr_ie, rd_en, hw_en, hw_trig, cont_en;
  logic [GW-1:0]   wr_grp, rd_grp, done_grp;
  logic [CHW-1:0]  wr_ch, conv_ch;
  logic [1:0]      div_code;
  logic [2:0]      ls_code;
  logic [DW-1:0]   smp_data, rd_data, done_data;
  logic            active, done_pulse, irq;
  logic [NGRP-1:0] flags;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ready = 0;

  typedef struct { int grp; int when; } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(input int k);
    logic [31:0] t;
    t = k * 37 + 11;
    return t[DW-1:0];
  endfunction

  assign smp_data = pat(cyc);

  adc_group_seq #(.NGRP(NGRP), .GW(GW), .CHW(CHW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp), .wr_ch(wr_ch),
    .wr_ie(wr_ie), .rd_en(rd_en), .rd_grp(rd_grp), .rd_data(rd_data),
    .hw_en(hw_en), .hw_trig(hw_trig), .cont_en(cont_en), .div_code(div_code),
    .ls_code(ls_code), .smp_data(smp_data), .active(active), .conv_ch(conv_ch),
    .done_pulse(done_pulse), .done_grp(done_grp), .done_data(done_data),
    .flags(flags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // monitor: every done strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (ready && done_pulse) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R2", "unexpected done strobe", cyc, -1);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(cyc == e.when, "R2", "done cycle", cyc, e.when);
        chk(int'(done_grp) == e.grp, "R2", "done group", int'(done_grp), e.grp);
        chk(done_data == pat(e.when - 1), "R2", "done data",
            int'(done_data), int'(pat(e.when - 1)));
      end
    end
  end

  task automatic push(input int g, input int when);
    exp_t e;
    e.grp = g;
    e.when = when;
    sbq.push_back(e);
  endtask

  task automatic wr(input int g, input int ch, input bit ie, output int s);
    @(negedge clk);
    wr_en = 1'b1; wr_grp = GW'(g); wr_ch = CHW'(ch); wr_ie = ie;
    s = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trig(output int s);
    @(negedge clk);
    hw_trig = 1'b1;
    s = cyc + 1;
    @(negedge clk);
    hw_trig = 1'b0;
  endtask

  task automatic rd(input int g, input int exp_val, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_grp = GW'(g);
    #1;
    chk(int'(rd_data) == exp_val, req, "read data", int'(rd_data), exp_val);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic waitc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    int s, r1;
    int dv[4] = '{1, 2, 3, 0};
    int lc[4] = '{0, 1, 3, 2};
    int nn[4] = '{76, 120, 160, 24};
    rst_n = 1'b0; wr_en = 0; wr_grp = '0; wr_ch = '0; wr_ie = 0;
    rd_en = 0; rd_grp = '0; hw_en = 0; hw_trig = 0; cont_en = 0;
    div_code = 2'd0; ls_code = 3'd4;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ready = 1;

    // R1 reset state
    chk(active == 0, "R1", "active", active, 0);
    chk(done_pulse == 0, "R1", "done_pulse", done_pulse, 0);
    chk(irq == 0, "R1", "irq", irq, 0);
    chk(flags == '0, "R1", "flags", int'(flags), 0);

    // R2 / R4 software start, base sample length: 4+12+2 = 18 clocks
    wr(0, 7, 1'b1, s);
    chk(active == 1, "R2", "active after start", active, 1);
    chk(int'(conv_ch) == 7, "R2", "conv_ch", int'(conv_ch), 7);
    push(0, s + 18);
    waitc(s + 17);
    chk(active == 1, "R4", "active before end", active, 1);
    waitc(s + 18);
    chk(active == 0, "R4", "active at end", active, 0);
    chk(flags[0] == 1, "R9", "flag0 set", flags[0], 1);
    chk(irq == 1, "R9", "irq with enable", irq, 1);

    // R10 read returns result and clears flag
    rd(0, int'(pat(s + 17)), "R10");
    chk(flags[0] == 0, "R10", "flag0 after read", flags[0], 0);
    chk(irq == 0, "R10", "irq after read", irq, 0);

    // R5 write to group 1 in software mode is silent
    wr(1, 3, 1'b1, s);
    waitc(s + 40);
    chk(active == 0, "R5", "no start from group 1", active, 0);
    chk(flags[1] == 0, "R5", "group 1 flag", flags[1], 0);

    // R3 / R4 divider and sample-length combinations
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      div_code = 2'(dv[i]); ls_code = 3'(lc[i]);
      wr(0, i + 1, 1'b0, s);
      chk(flags[0] == 0, "R10", "write clears flag", flags[0], 0);
      push(0, s + nn[i]);
      waitc(s + nn[i] - 1);
      chk(active == 1, "R3", "active before end", active, 1);
      waitc(s + nn[i]);
      chk(active == 0, "R3", "active at end", active, 0);
      chk(irq == 0, "R9", "irq with enable off", irq, 0);
    end
    @(negedge clk);
    div_code = 2'd0; ls_code = 3'd4;

    // R6 / R7 / R8 hardware mode
    hw_en = 1'b1;
    wr(0, 4, 1'b1, s);
    chk(active == 0, "R6", "write does not start", active, 0);
    wr(1, 9, 1'b1, s);
    chk(active == 0, "R6", "write does not start", active, 0);
    trig(s);
    chk(active == 1, "R6", "trigger starts", active, 1);
    chk(int'(conv_ch) == 4, "R6", "first turn group 0", int'(conv_ch), 4);
    waitc(s + 5);
    wr(0, 4, 1'b1, s);
    chk(active == 0, "R7", "abort drops active", active, 0);
    waitc(s + 30);
    chk(flags[0] == 0, "R7", "no flag after abort", flags[0], 0);

    trig(s);
    chk(int'(conv_ch) == 9, "R6", "second turn group 1", int'(conv_ch), 9);
    push(1, s + 18);
    r1 = int'(pat(s + 17));
    begin
      int t;
      waitc(s + 3);
      wr(0, 4, 1'b1, t);
      chk(active == 1, "R8", "idle-group write keeps active", active, 1);
      trig(t);
      chk(active == 1, "R6", "busy trigger ignored", active, 1);
    end
    waitc(s + 18);
    chk(active == 0, "R8", "normal end", active, 0);
    chk(flags[1] == 1, "R9", "flag1 set", flags[1], 1);
    chk(irq == 1, "R9", "irq group 1", irq, 1);

    trig(s);
    chk(int'(conv_ch) == 4, "R6", "pointer wraps to group 0", int'(conv_ch), 4);
    push(0, s + 18);
    waitc(s + 18);
    chk(flags == 2'b11, "R9", "both flags", int'(flags), 3);
    rd(1, r1, "R10");
    chk(flags[1] == 0, "R10", "flag1 after read", flags[1], 0);
    rd(0, int'(pat(s + 17)), "R10");

    // R11 continuous mode
    @(negedge clk);
    hw_en = 1'b0; cont_en = 1'b1;
    wr(0, 2, 1'b0, s);
    push(0, s + 18); push(0, s + 36); push(0, s + 54);
    waitc(s + 19);
    chk(active == 1, "R11", "restart after first", active, 1);
    waitc(s + 37);
    chk(active == 1, "R11", "restart after second", active, 1);
    cont_en = 1'b0;
    waitc(s + 53);
    chk(active == 1, "R11", "third still running", active, 1);
    waitc(s + 54);
    chk(active == 0, "R11", "stops when mode off", active, 0);
    waitc(s + 80);
    chk(active == 0, "R11", "stays idle", active, 0);
    chk(sbq.size() == 0, "R2", "scoreboard drained", sbq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual %0d expected 0 hung cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule